// File: doc/BRIEF.md
# Audio Sample and Command FIFO Bridge

This block joins a byte-wide host register port to a telephone-quality audio converter. The host writes playback bytes into an outbound FIFO and reads capture bytes from an inbound FIFO. Codec command bytes go into a separate control FIFO that the host can only write. On the converter side, a sample strobe from the pacing logic moves one sample per strobe: one byte in 8-bit mode, two bytes (most significant first) in 16-bit mode. The control FIFO hands its bytes to a command consumer through a valid/ready pair.

A control/status register holds the global interrupt enable, the sample width, and separate connect switches for the data path and the command path. An interrupt register keeps four sticky events in its low nibble and the matching enables in its high nibble. The events are: capture FIFO at least half full, playback FIFO below half, playback FIFO empty, and control FIFO empty. A status register shows full and empty for every FIFO. A write to address 0 clears the whole block, and a read there returns a fixed identity byte.

Top module: `audio_fifo_bridge`

## Requirements
- R1: After the reset pin or any host write to address 0, the block is in its reset state on the next cycle. Address 1 reads 0x00, address 2 reads 0x00, address 3 reads 0x15 (all FIFOs empty), and address 0 reads the ID_VALUE parameter (default 0xA7).
- R2: In the control/status register at address 1, bits 7 (interrupt enable), 3 (16-bit samples), 2 (command path on) and 0 (data path on) are writable and read back. Bit 6 is a read-only request flag, and every other bit reads 0.
- R3: A write to address 4 pushes into the 128-byte playback FIFO, and a read of address 4 pops the capture FIFO in arrival order. Address 3 reads {2'b00, ctrl_full, ctrl_empty, out_full, out_empty, in_full, in_empty}.
- R4: A push into a full FIFO is dropped. A pop of an empty FIFO returns the last byte popped from it (0x00 after reset) and leaves the status unchanged.
- R5: While bit 0 of address 1 is clear, a sample strobe stores no capture byte and releases no playback sample.
- R6: In 8-bit mode, each strobe pushes cap_sample[7:0] and pops one playback byte b, which appears as play_sample = {8'h00, b} with a one-cycle play_valid pulse.
- R7: In 16-bit mode, each strobe pushes cap_sample[15:8] and then cap_sample[7:0] on the next cycle. It pops two playback bytes and presents the first byte in play_sample[15:8] and the second in play_sample[7:0].
- R8: Bytes written to address 5 collect in the control FIFO while bit 2 of address 1 is clear, with cmd_valid low. Once bit 2 is set, they leave in write order, one per cycle in which cmd_valid and cmd_ready are both high.
- R9: Address 2 bits 3..0 are events: bit 3 playback FIFO empty, bit 2 control FIFO empty, bit 1 playback level below 64, bit 0 capture level at least 64. An event latches when its condition becomes true and stays set while the condition holds. A written 1 clears it only once the condition has ended.
- R10: The request flag (bit 6 of address 1) is the OR of event[i] AND enable[i], where enable[i] is bit i+4 of address 2. irq equals that flag ANDed with bit 7 of address 1.
- R11: With 8-bit capture, only the capture event enabled, and the host draining 64 bytes and clearing the event after each interrupt, irq rises exactly once per 64 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Host register address |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, one cycle (pops at address 4) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational from bus_addr |
| smp_tick | input | 1 | Sample strobe from the pacing logic |
| cap_sample | input | 16 | Capture sample from the converter |
| play_sample | output | 16 | Last playback sample released |
| play_valid | output | 1 | One-cycle pulse when play_sample is updated |
| cmd_data | output | 8 | Command byte at the control FIFO head |
| cmd_valid | output | 1 | Command byte available and command path on |
| cmd_ready | input | 1 | Command consumer accepts the byte |
| irq | output | 1 | Level interrupt request |

## Verification
Register writes and FIFO pops take effect at the clock edge that samples the strobe. Read data is combinational, so the bench samples it one time unit after it drives the address, before that edge. A playback sample appears one edge after the strobe in 8-bit mode and two edges after it in 16-bit mode. An event, and the irq it feeds, appears one edge after the FIFO level changes, so up to two edges after the strobe or host access that caused it. Every strobe task therefore waits three falling edges before any output is compared, and command bytes are logged at each clock edge that transfers one.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam logic [2:0] A_IDENT  = 3'd0;
  localparam logic [2:0] A_CTRL   = 3'd1;
  localparam logic [2:0] A_EVENTS = 3'd2;
  localparam logic [2:0] A_STATUS = 3'd3;
  localparam logic [2:0] A_DATA   = 3'd4;
  localparam logic [2:0] A_CMD    = 3'd5;

  localparam int B_GIE   = 7;
  localparam int B_REQ   = 6;
  localparam int B_WIDE  = 3;
  localparam int B_CMDON = 2;
  localparam int B_DATON = 0;

  localparam int NUM_EV      = 4;
  localparam int EV_IN_HALF  = 0;
  localparam int EV_OUT_HALF = 1;
  localparam int EV_CMD_MT   = 2;
  localparam int EV_OUT_MT   = 3;

  // condition values right after a clear: all FIFOs empty
  localparam logic [NUM_EV-1:0] COND_AT_CLEAR = 4'b1110;
endpackage

// File: rtl/glue_byte_fifo.sv
module glue_byte_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic             half
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WIDTH-1:0] last_q, last_d;
  logic [WIDTH-1:0] mem [DEPTH];
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign half    = (cnt_q >= CW'(HALF));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = empty ? last_q : mem[rd_q];

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (flush) begin
      wr_d   = '0;
      rd_d   = '0;
      cnt_d  = '0;
      last_d = '0;
    end else begin
      if (do_push) wr_d = bump(wr_q);
      if (do_pop) begin
        rd_d   = bump(rd_q);
        last_d = mem[rd_q];
      end
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_q] <= din;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)) else $error("fifo level above depth"); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(cnt_q))) else $error("push into full fifo changed it"); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (empty && $stable(dout))) else $error("pop of empty fifo changed it"); // R4
endmodule

// File: rtl/glue_cap_packer.sv
module glue_cap_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        tick,
  input  logic        en,
  input  logic        wide,
  input  logic [15:0] sample,
  output logic        push_o,
  output logic [7:0]  byte_o
);
  logic       pend_q, pend_d;
  logic [7:0] lo_q, lo_d;
  logic       take;

  assign take = tick & en & ~pend_q;

  always_comb begin
    pend_d = 1'b0;
    lo_d   = lo_q;
    push_o = 1'b0;
    byte_o = 8'h00;
    if (pend_q) begin
      push_o = 1'b1;
      byte_o = lo_q;
    end else if (take) begin
      push_o = 1'b1;
      byte_o = wide ? sample[15:8] : sample[7:0];
      if (wide) begin
        pend_d = 1'b1;
        lo_d   = sample[7:0];
      end
    end
    if (flush) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lo_q   <= 8'h00;
    end else begin
      pend_q <= pend_d;
      lo_q   <= lo_d;
    end
  end

  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && wide && !pend_q && !flush) |=> push_o) else $error("second byte not pushed"); // R7
endmodule

// File: rtl/glue_play_unpacker.sv
module glue_play_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        tick,
  input  logic        en,
  input  logic        wide,
  input  logic [7:0]  head,
  output logic        pop_o,
  output logic [15:0] sample_o,
  output logic        valid_o
);
  logic        pend_q, pend_d;
  logic [7:0]  hi_q, hi_d;
  logic [15:0] smp_q, smp_d;
  logic        vld_d;
  logic        take;

  assign take     = tick & en & ~pend_q;
  assign pop_o    = pend_q | take;
  assign sample_o = smp_q;

  always_comb begin
    pend_d = 1'b0;
    hi_d   = hi_q;
    smp_d  = smp_q;
    vld_d  = 1'b0;
    if (pend_q) begin
      smp_d = {hi_q, head};
      vld_d = 1'b1;
    end else if (take) begin
      if (wide) begin
        hi_d   = head;
        pend_d = 1'b1;
      end else begin
        smp_d = {8'h00, head};
        vld_d = 1'b1;
      end
    end
    if (flush) begin
      pend_d = 1'b0;
      smp_d  = '0;
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      hi_q    <= 8'h00;
      smp_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      hi_q    <= hi_d;
      smp_q   <= smp_d;
      valid_o <= vld_d;
    end
  end

  AST_VALID_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_o && !flush && !(tick && en && wide && !pend_q)) |=> valid_o) else $error("sample not released"); // R6
endmodule

// File: rtl/glue_event_unit.sv
module glue_event_unit #(
  parameter int                 NEV      = 4,
  parameter logic [NEV-1:0]     RST_COND = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic [NEV-1:0] cond,
  input  logic           clr_we,
  input  logic [NEV-1:0] clr_bits,
  input  logic [NEV-1:0] enable,
  output logic [NEV-1:0] evt,
  output logic           req
);
  logic [NEV-1:0] evt_d, cond_q, cond_d;

  assign req = |(evt & enable);

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    always_comb begin
      if (flush) begin
        evt_d[i]  = 1'b0;
        cond_d[i] = RST_COND[i];
      end else begin
        evt_d[i]  = (cond[i] & ~cond_q[i]) |
                    (evt[i] & ~(clr_we & clr_bits[i] & ~cond[i]));
        cond_d[i] = cond[i];
      end
    end

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && cond[i] && !flush) |=> evt[i]) else $error("event dropped while condition held"); // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt    <= '0;
      cond_q <= RST_COND;
    end else begin
      evt    <= evt_d;
      cond_q <= cond_d;
    end
  end
endmodule

// File: rtl/audio_fifo_bridge.sv
module audio_fifo_bridge
  import glue_pkg::*;
#(
  parameter int         DEPTH    = 128,
  parameter logic [7:0] ID_VALUE = 8'hA7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        smp_tick,
  input  logic [15:0] cap_sample,
  output logic [15:0] play_sample,
  output logic        play_valid,
  output logic [7:0]  cmd_data,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic        irq
);
  logic soft_clr;
  logic gie_q, gie_d, wide_q, wide_d, cmdon_q, cmdon_d, daton_q, daton_d;
  logic [NUM_EV-1:0] ien_q, ien_d, evt, cond;
  logic req;

  logic       cap_push, cap_pop, cap_full, cap_empty, cap_half;
  logic [7:0] cap_byte, cap_dout;
  logic       out_push, out_pop, out_full, out_empty, out_half;
  logic [7:0] out_dout;
  logic       cmd_push, cmd_pop, cmd_full, cmd_empty, cmd_half;

  assign soft_clr = bus_wr && (bus_addr == A_IDENT);
  assign out_push = bus_wr && (bus_addr == A_DATA);
  assign cmd_push = bus_wr && (bus_addr == A_CMD);
  assign cap_pop  = bus_rd && (bus_addr == A_DATA);

  // control/status and interrupt-enable next state
  always_comb begin
    gie_d   = gie_q;
    wide_d  = wide_q;
    cmdon_d = cmdon_q;
    daton_d = daton_q;
    ien_d   = ien_q;
    if (soft_clr) begin
      gie_d   = 1'b0;
      wide_d  = 1'b0;
      cmdon_d = 1'b0;
      daton_d = 1'b0;
      ien_d   = '0;
    end else if (bus_wr && bus_addr == A_CTRL) begin
      gie_d   = bus_wdata[B_GIE];
      wide_d  = bus_wdata[B_WIDE];
      cmdon_d = bus_wdata[B_CMDON];
      daton_d = bus_wdata[B_DATON];
    end else if (bus_wr && bus_addr == A_EVENTS) begin
      ien_d = bus_wdata[2*NUM_EV-1:NUM_EV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      wide_q  <= 1'b0;
      cmdon_q <= 1'b0;
      daton_q <= 1'b0;
      ien_q   <= '0;
    end else begin
      gie_q   <= gie_d;
      wide_q  <= wide_d;
      cmdon_q <= cmdon_d;
      daton_q <= daton_d;
      ien_q   <= ien_d;
    end
  end

  glue_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_cap_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_clr),
    .push(cap_push), .din(cap_byte), .pop(cap_pop),
    .dout(cap_dout), .full(cap_full), .empty(cap_empty), .half(cap_half));

  glue_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_clr),
    .push(out_push), .din(bus_wdata), .pop(out_pop),
    .dout(out_dout), .full(out_full), .empty(out_empty), .half(out_half));

  glue_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_cmd_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_clr),
    .push(cmd_push), .din(bus_wdata), .pop(cmd_pop),
    .dout(cmd_data), .full(cmd_full), .empty(cmd_empty), .half(cmd_half));

  glue_cap_packer u_packer (
    .clk(clk), .rst_n(rst_n), .flush(soft_clr),
    .tick(smp_tick), .en(daton_q), .wide(wide_q), .sample(cap_sample),
    .push_o(cap_push), .byte_o(cap_byte));

  glue_play_unpacker u_unpacker (
    .clk(clk), .rst_n(rst_n), .flush(soft_clr),
    .tick(smp_tick), .en(daton_q), .wide(wide_q), .head(out_dout),
    .pop_o(out_pop), .sample_o(play_sample), .valid_o(play_valid));

  assign cmd_valid = cmdon_q & ~cmd_empty;
  assign cmd_pop   = cmd_valid & cmd_ready;

  always_comb begin
    cond              = '0;
    cond[EV_IN_HALF]  = cap_half;
    cond[EV_OUT_HALF] = ~out_half;
    cond[EV_CMD_MT]   = cmd_empty;
    cond[EV_OUT_MT]   = out_empty;
  end

  glue_event_unit #(.NEV(NUM_EV), .RST_COND(COND_AT_CLEAR)) u_events (
    .clk(clk), .rst_n(rst_n), .flush(soft_clr), .cond(cond),
    .clr_we(bus_wr && bus_addr == A_EVENTS), .clr_bits(bus_wdata[NUM_EV-1:0]),
    .enable(ien_q), .evt(evt), .req(req));

  assign irq = gie_q & req;

  always_comb begin
    case (bus_addr)
      A_IDENT:  bus_rdata = ID_VALUE;
      A_CTRL:   bus_rdata = {gie_q, req, 2'b00, wide_q, cmdon_q, 1'b0, daton_q};
      A_EVENTS: bus_rdata = {ien_q, evt};
      A_STATUS: bus_rdata = {2'b00, cmd_full, cmd_empty, out_full, out_empty, cap_full, cap_empty};
      A_DATA:   bus_rdata = cap_dout;
      default:  bus_rdata = 8'h00;
    endcase
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !soft_clr && !(bus_wr && bus_addr == A_CTRL))
      |=> (cmd_valid && $stable(cmd_data))) else $error("command byte not held"); // R8
  AST_CMD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_half |-> !cmd_empty) else $error("control fifo level flags disagree"); // R8
endmodule

// File: tb/sim_audio_fifo_bridge.sv
module sim_audio_fifo_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        smp_tick = 1'b0;
  logic [15:0] cap_sample = '0;
  logic [15:0] play_sample;
  logic        play_valid;
  logic [7:0]  cmd_data;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  int play_cnt = 0, cmd_n = 0, irq_rises = 0;
  logic irq_d = 1'b0;
  logic [7:0] cmd_log [8];

  always #10 clk = ~clk;

  audio_fifo_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_tick(smp_tick),
    .cap_sample(cap_sample), .play_sample(play_sample), .play_valid(play_valid),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .irq(irq));

  always @(posedge clk) begin
    if (play_valid) play_cnt <= play_cnt + 1;
    if (cmd_valid && cmd_ready) begin
      cmd_log[cmd_n[2:0]] <= cmd_data;
      cmd_n <= cmd_n + 1;
    end
    irq_d <= irq;
    if (irq && !irq_d) irq_rises <= irq_rises + 1;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); smp_tick = 1'b1;
    @(negedge clk); smp_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, int'(d), int'(exp));
  endtask

  // {op(1=read check), req number, addr, data, expected}
  localparam int NV = 19;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 5'd1, 3'd1, 8'h00, 8'h00},
    {1'b1, 5'd1, 3'd2, 8'h00, 8'h00},
    {1'b1, 5'd1, 3'd3, 8'h00, 8'h15},
    {1'b1, 5'd1, 3'd0, 8'h00, 8'hA7},
    {1'b0, 5'd2, 3'd1, 8'h8D, 8'h00},
    {1'b1, 5'd2, 3'd1, 8'h00, 8'h8D},
    {1'b0, 5'd2, 3'd1, 8'hFF, 8'h00},
    {1'b1, 5'd2, 3'd1, 8'h00, 8'h8D},
    {1'b0, 5'd2, 3'd1, 8'h00, 8'h00},
    {1'b0, 5'd3, 3'd4, 8'h11, 8'h00},
    {1'b0, 5'd3, 3'd4, 8'h22, 8'h00},
    {1'b1, 5'd3, 3'd3, 8'h00, 8'h11},
    {1'b1, 5'd4, 3'd4, 8'h00, 8'h00},
    {1'b1, 5'd4, 3'd3, 8'h00, 8'h11},
    {1'b0, 5'd8, 3'd5, 8'hC1, 8'h00},
    {1'b1, 5'd8, 3'd3, 8'h00, 8'h01},
    {1'b0, 5'd1, 3'd0, 8'h00, 8'h00},
    {1'b1, 5'd1, 3'd3, 8'h00, 8'h15},
    {1'b1, 5'd1, 3'd1, 8'h00, 8'h00}
  };

  initial begin
    logic [7:0] d;
    int base, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R8: register vectors
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) begin
        rd(VEC[v][18:16], d);
        chk($sformatf("R%0d vector %0d", VEC[v][23:19], v), int'(d), int'(VEC[v][7:0]));
      end else begin
        wr(VEC[v][18:16], VEC[v][15:8]);
      end
    end

    // R6 capture, 8-bit
    wr(3'd1, 8'h01);
    cap_sample = 16'h1234;
    tick();
    rchk("R6 8-bit capture byte", 3'd4, 8'h34);
    // R7 capture, 16-bit, MSB first
    wr(3'd1, 8'h09);
    cap_sample = 16'hBEEF;
    tick();
    rchk("R7 16-bit capture first", 3'd4, 8'hBE);
    rchk("R7 16-bit capture second", 3'd4, 8'hEF);
    // R5 data path off
    wr(3'd1, 8'h08);
    wr(3'd4, 8'h5A);
    base = play_cnt;
    tick();
    rchk("R5 no capture while off", 3'd3, 8'h11);
    chk("R5 no playback while off", play_cnt - base, 0);
    // R7 playback, 16-bit
    wr(3'd4, 8'hC3);
    wr(3'd1, 8'h09);
    tick();
    chk("R7 16-bit playback sample", int'(play_sample), 16'h5AC3);
    chk("R7 one release", play_cnt - base, 1);
    // R6 playback, 8-bit
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h77);
    wr(3'd1, 8'h01);
    tick();
    chk("R6 8-bit playback sample", int'(play_sample), 16'h0077);

    // R8 control FIFO
    wr(3'd0, 8'h00);
    base = cmd_n;
    wr(3'd5, 8'hA1); wr(3'd5, 8'hA2); wr(3'd5, 8'hA3);
    repeat (3) @(negedge clk);
    chk("R8 held while command path off", cmd_n - base, 0);
    rchk("R8 control fifo not empty", 3'd3, 8'h05);
    wr(3'd1, 8'h04);
    repeat (5) @(negedge clk);
    chk("R8 three bytes released", cmd_n - base, 3);
    chk("R8 order byte 0", int'(cmd_log[base[2:0]]), 8'hA1);
    chk("R8 order byte 1", int'(cmd_log[3'(base + 1)]), 8'hA2);
    chk("R8 order byte 2", int'(cmd_log[3'(base + 2)]), 8'hA3);
    rchk("R9 control empty event", 3'd2, 8'h04);

    // R10 request flag and gating
    wr(3'd2, 8'h40);
    rchk("R10 request flag without gie", 3'd1, 8'h44);
    chk("R10 irq off without gie", int'(irq), 0);
    wr(3'd1, 8'h84);
    chk("R10 irq on with gie", int'(irq), 1);
    wr(3'd2, 8'h44);
    rchk("R9 clear ignored while condition holds", 3'd2, 8'h44);
    wr(3'd1, 8'h80);
    wr(3'd5, 8'hB0);
    wr(3'd2, 8'h44);
    rchk("R9 clear after condition ends", 3'd2, 8'h40);
    chk("R10 irq drops after clear", int'(irq), 0);

    // R3 R4 R9 full playback FIFO, drain through the converter side
    wr(3'd0, 8'h00);
    cap_sample = 16'h0000;
    for (int i = 0; i < 130; i++) wr(3'd4, 8'(i));
    rchk("R4 full after overfill", 3'd3, 8'h19);
    wr(3'd1, 8'h01);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      tick();
      if (play_sample != {8'h00, 8'(i)}) bad++;
      if (i == 63) rchk("R9 events at 64 released", 3'd2, 8'h01);
      if (i == 64) rchk("R9 output below half", 3'd2, 8'h03);
    end
    chk("R3 playback order over 128 bytes", bad, 0);
    rchk("R9 output empty event", 3'd2, 8'h0B);
    rchk("R3 status after drain", 3'd3, 8'h16);
    tick();
    chk("R4 empty pop repeats last", int'(play_sample), 16'h007F);
    rchk("R4 status unchanged", 3'd3, 8'h16);

    // R11 one interrupt per 64 captured samples
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h10);
    wr(3'd1, 8'h81);
    base = irq_rises;
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 63; k++) begin
        cap_sample = 16'(r * 64 + k);
        tick();
      end
      chk("R11 no irq before 64th sample", int'(irq), 0);
      cap_sample = 16'(r * 64 + 63);
      tick();
      chk("R11 irq at 64th sample", int'(irq), 1);
      bad = 0;
      for (int k = 0; k < 64; k++) begin
        rd(3'd4, d);
        if (d != 8'(r * 64 + k)) bad++;
      end
      chk("R11 drained bytes", bad, 0);
      wr(3'd2, 8'h11);
      chk("R11 irq cleared", int'(irq), 0);
    end
    chk("R11 interrupt count", irq_rises - base, 3);

    summary();
    $finish;
  end
endmodule